// File: doc/BRIEF.md
# Bidirectional Handshaked Byte Port

This block is one byte-wide port that moves data both ways between a host processor and a second processor or controller over a single set of shared pins. A host write loads an output latch and lowers the output-buffer-full line (`obf_n`). The peripheral collects the byte by pulling `ack_n` low. The block drives the pins from the output latch only while `ack_n` is low, and leaves them released at every other time. This lets the peripheral use the same pins to present its own byte. It latches that byte into a separate input latch on a falling edge of `stb_n`, and reports it on the input-buffer-full line `ibf`. A host read of the data address returns the input latch and empties it.

Each direction is a small state machine. The output side has three states. `OUT_IDLE` is the state after reset, with no byte pending. `OUT_FULL` holds a byte waiting for the peripheral. `OUT_TAKEN` means the peripheral has acknowledged the byte. The transitions are: a host write moves any state to `OUT_FULL`, and a falling edge on `ack_n` moves `OUT_FULL` to `OUT_TAKEN`. The input side has two states. A falling edge on `stb_n` moves `IN_EMPTY` to `IN_FULL`, and a host data read moves `IN_FULL` back to `IN_EMPTY`.

The status address reports the handshake lines. Writes to the status address that have bit 7 clear set or clear one of the two interrupt enables, chosen by a bit index. A single interrupt line `intr` serves both directions.

Top module: `bidir_hs_port`

## Requirements
- R1: While `rst_n` is low, `obf_n`=1, `ibf`=0, `intr`=0 and `pad_oe`=0, and both interrupt enables read back as 0.
- R2: A write cycle (`host_wr`=1, `host_sel`=0) loads `host_wdata` into the output latch, and `obf_n` reads 0 after that clock edge.
- R3: `pad_oe` is 1 exactly while `ack_n` is 0. While `pad_oe` is 1, `pad_out` equals the output latch.
- R4: A falling edge of `ack_n` (sampled 1 then 0 on successive clocks) while `obf_n`=0 sets `obf_n` to 1 after that edge.
- R5: A falling edge of `stb_n` while `ibf`=0 captures `pad_in` into the input latch, and `ibf` reads 1 after that edge.
- R6: A falling edge of `stb_n` while `ibf`=1 is ignored, and the input latch keeps its byte.
- R7: `host_rdata` with `host_sel`=0 shows the input latch. A read cycle (`host_rd`=1, `host_sel`=0) while `ibf`=1 clears `ibf` after that edge.
- R8: `host_rdata` with `host_sel`=1 is the status byte: bit 7 `obf_n`, bit 6 the output interrupt enable, bit 5 `ibf`, bit 4 the input interrupt enable, bit 3 `intr`, bits 2..0 zero.
- R9: A write cycle with `host_sel`=1 and `host_wdata[7]`=0 copies `host_wdata[0]` into the output interrupt enable when `host_wdata[3:1]`=6, or into the input interrupt enable when it is 4. Any other index, and any status-address write with bit 7 set, changes nothing.
- R10: `intr` = (`ibf` AND input enable) OR (state `OUT_TAKEN` AND `ack_n`=1 AND output enable).
- R11: When a data write and an `ack_n` falling edge fall in the same cycle, the write wins and `obf_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host address: 0 data, 1 status/bit-set |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected address |
| pad_in | input | 8 | Pin values presented by the peripheral |
| pad_out | output | 8 | Pin drive value from the output latch |
| pad_oe | output | 1 | Pin output enable |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Shared interrupt request |

## Verification
The assertions assume that `ack_n`, `stb_n` and the host strobes are synchronous to `clk`. They also assume that a host access lasts exactly one clock and that the host never asserts a read and a write in the same cycle. The stimulus changes every input just after a falling clock edge and holds each host strobe for one rising edge only, so it stays within these assumptions. It still drives the overlaps named in the requirements: a strobe while the input latch is full, and an acknowledge in the same cycle as a write.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    typedef enum logic [1:0] {OUT_IDLE, OUT_FULL, OUT_TAKEN} out_state_t;
    typedef enum logic {IN_EMPTY, IN_FULL} in_state_t;

    localparam int STAT_OBF    = 7;
    localparam int STAT_IEN_O  = 6;
    localparam int STAT_IBF    = 5;
    localparam int STAT_IEN_I  = 4;
    localparam int STAT_INTR   = 3;

    localparam int BITIDX_IEN_O = 6;
    localparam int BITIDX_IEN_I = 4;
    localparam int BITIDX_W     = 3;
endpackage

// File: rtl/bhp_out_fsm.sv
module bhp_out_fsm
    import bhp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    input  logic         ack_n,
    output logic [W-1:0] out_latch,
    output logic         obf_n,
    output logic         taken
);
    out_state_t state, state_nx;
    logic ack_q;
    logic ack_fall;

    assign ack_fall = ack_q && !ack_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OUT_IDLE;
            ack_q <= 1'b1;
        end else begin
            state <= state_nx;
            ack_q <= ack_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_latch <= '0;
        else if (load) out_latch <= wdata;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_IDLE:  if (load) state_nx = OUT_FULL;
            OUT_FULL:  if (!load && ack_fall) state_nx = OUT_TAKEN;
            OUT_TAKEN: if (load) state_nx = OUT_FULL;
            default:   state_nx = OUT_IDLE;
        endcase
    end

    always_comb begin
        obf_n = 1'b1;
        taken = 1'b0;
        unique case (state)
            OUT_IDLE:  ;
            OUT_FULL:  obf_n = 1'b0;
            OUT_TAKEN: taken = 1'b1;
            default:   ;
        endcase
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !obf_n); // R2
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !ack_n && !obf_n && !load) |=> obf_n); // R4
    AST_WRITE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ack_q && !ack_n) |=> (!obf_n && out_latch == $past(wdata))); // R11
endmodule

// File: rtl/bhp_in_fsm.sv
module bhp_in_fsm
    import bhp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_n,
    input  logic [W-1:0] pad_in,
    input  logic         take,
    output logic [W-1:0] in_latch,
    output logic         ibf
);
    in_state_t state, state_nx;
    logic stb_q;
    logic stb_fall;
    logic capture;

    assign stb_fall = stb_q && !stb_n;
    assign capture  = (state == IN_EMPTY) && stb_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IN_EMPTY;
            stb_q <= 1'b1;
        end else begin
            state <= state_nx;
            stb_q <= stb_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_latch <= '0;
        else if (capture) in_latch <= pad_in;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IN_EMPTY: if (stb_fall) state_nx = IN_FULL;
            IN_FULL:  if (take) state_nx = IN_EMPTY;
            default:  state_nx = IN_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state)
            IN_FULL: ibf = 1'b1;
            default: ibf = 1'b0;
        endcase
    end

    AST_STROBE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && !stb_n && !ibf) |=> (ibf && in_latch == $past(pad_in))); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !take) |=> $stable(in_latch)); // R6
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && take) |=> !ibf); // R7
endmodule

// File: rtl/bhp_ctrl.sv
module bhp_ctrl
    import bhp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_wr,
    input  logic [BITIDX_W:0]   bit_cmd,
    input  logic                host_sel,
    input  logic [W-1:0]        in_latch,
    input  logic                obf_n,
    input  logic                ibf,
    input  logic                taken,
    input  logic                ack_n,
    output logic [W-1:0]        rdata,
    output logic                intr
);
    logic ien_o, ien_i;
    logic [BITIDX_W-1:0] idx;
    logic [W-1:0] status;

    assign idx = bit_cmd[BITIDX_W:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_o <= 1'b0;
            ien_i <= 1'b0;
        end else if (bit_wr) begin
            if (idx == BITIDX_W'(BITIDX_IEN_O)) ien_o <= bit_cmd[0];
            if (idx == BITIDX_W'(BITIDX_IEN_I)) ien_i <= bit_cmd[0];
        end
    end

    always_comb begin
        intr = (ibf && ien_i) || (taken && ack_n && ien_o);
    end

    always_comb begin
        status             = '0;
        status[STAT_OBF]   = obf_n;
        status[STAT_IEN_O] = ien_o;
        status[STAT_IBF]   = ibf;
        status[STAT_IEN_I] = ien_i;
        status[STAT_INTR]  = intr;
        rdata = host_sel ? status : in_latch;
    end

    AST_IN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && ien_i) |-> intr); // R10
    AST_NO_IRQ_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!obf_n && !(ibf && ien_i)) |-> !intr); // R10
    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && idx == BITIDX_W'(BITIDX_IEN_I)) |=> (ien_i == $past(bit_cmd[0]))); // R9
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
    import bhp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_sel,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic         pad_oe,
    input  logic         ack_n,
    input  logic         stb_n,
    output logic         obf_n,
    output logic         ibf,
    output logic         intr
);
    logic data_wr, bit_wr, data_rd, taken;
    logic [W-1:0] out_latch, in_latch;

    assign data_wr = host_wr && !host_sel;
    assign bit_wr  = host_wr && host_sel && !host_wdata[W-1];
    assign data_rd = host_rd && !host_sel;

    bhp_out_fsm #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(data_wr), .wdata(host_wdata),
        .ack_n(ack_n), .out_latch(out_latch), .obf_n(obf_n), .taken(taken)
    );

    bhp_in_fsm #(.W(W)) u_in (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pad_in(pad_in),
        .take(data_rd), .in_latch(in_latch), .ibf(ibf)
    );

    bhp_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_wr(bit_wr),
        .bit_cmd(host_wdata[BITIDX_W:0]), .host_sel(host_sel),
        .in_latch(in_latch), .obf_n(obf_n), .ibf(ibf), .taken(taken),
        .ack_n(ack_n), .rdata(host_rdata), .intr(intr)
    );

    assign pad_oe  = !ack_n;
    assign pad_out = out_latch;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (obf_n && !ibf && !intr)); // R1
    AST_DRIVE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n && $past(data_wr)) |-> (!pad_oe && pad_out == $past(host_wdata))); // R3
endmodule

// File: tb/bidir_hs_port_bench.sv
module bidir_hs_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata, pad_in = '0, pad_out;
    logic pad_oe, ack_n = 1'b1, stb_n = 1'b1, obf_n, ibf, intr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bidir_hs_port u_bidir_hs_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .ack_n(ack_n),
        .stb_n(stb_n), .obf_n(obf_n), .ibf(ibf), .intr(intr)
    );

    // behavioural reference
    bit m_obf_n = 1, m_ibf = 0, m_taken = 0, m_ien_o = 0, m_ien_i = 0;
    bit m_ack_q = 1, m_stb_q = 1;
    logic [7:0] m_out = '0, m_in = '0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s%s actual=%h expected=%h t=%0t",
                     rst_n ? "" : "R1 ", tag, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #3;
        if (!rst_n) begin
            m_obf_n = 1; m_ibf = 0; m_taken = 0; m_ien_o = 0; m_ien_i = 0;
            m_ack_q = 1; m_stb_q = 1; m_out = '0; m_in = '0;
        end
        begin
            bit e_intr;
            logic [7:0] e_stat;
            e_intr = (m_ibf && m_ien_i) || (m_taken && ack_n && m_ien_o);
            e_stat = {m_obf_n, m_ien_o, m_ibf, m_ien_i, e_intr, 3'b000};
            chk("R2 R4 R11 obf_n", {7'b0, obf_n}, {7'b0, m_obf_n});
            chk("R5 R7 ibf", {7'b0, ibf}, {7'b0, m_ibf});
            chk("R10 intr", {7'b0, intr}, {7'b0, e_intr});
            chk("R3 pad_oe", {7'b0, pad_oe}, {7'b0, !ack_n});
            if (!ack_n) chk("R3 pad_out", pad_out, m_out);
            if (host_sel) chk("R8 R9 status", host_rdata, e_stat);
            else chk("R6 R7 rdata", host_rdata, m_in);
        end
        if (rst_n) begin
            if (host_wr && !host_sel) begin
                m_out = host_wdata; m_obf_n = 0; m_taken = 0;
            end else if (m_ack_q && !ack_n && !m_obf_n) begin
                m_obf_n = 1; m_taken = 1;
            end
            if (!m_ibf && m_stb_q && !stb_n) begin
                m_in = pad_in; m_ibf = 1;
            end else if (m_ibf && host_rd && !host_sel) begin
                m_ibf = 0;
            end
            if (host_wr && host_sel && !host_wdata[7]) begin
                if (host_wdata[3:1] == 3'd6) m_ien_o = host_wdata[0];
                if (host_wdata[3:1] == 3'd4) m_ien_i = host_wdata[0];
            end
            m_ack_q = ack_n;
            m_stb_q = stb_n;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic hwrite(logic sel, logic [7:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic hread(logic sel);
        host_sel = sel; host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic strobe(logic [7:0] d);
        pad_in = d; stb_n = 1'b0;
        tick(2);
        stb_n = 1'b1;
        tick();
    endtask

    task automatic acknowledge();
        ack_n = 1'b0;
        tick(2);
        ack_n = 1'b1;
        tick();
    endtask

    initial begin
        tick(3);                    // R1 reset state checked each cycle
        rst_n = 1'b1;
        tick();
        hread(1'b1);                // R8 status after reset
        hwrite(1'b0, 8'hA5);        // R2
        hwrite(1'b1, 8'h0D);        // R9 output enable on
        acknowledge();              // R3 R4 R10
        hread(1'b1);
        hwrite(1'b0, 8'h3C);        // R10 write clears taken interrupt
        hwrite(1'b1, 8'h0B);        // R9 index 5 ignored
        hwrite(1'b1, 8'h89);        // R9 bit 7 set ignored
        hread(1'b1);
        strobe(8'h5A);              // R5
        hwrite(1'b1, 8'h09);        // R9 input enable on, R10
        strobe(8'h77);              // R6 ignored while full
        hread(1'b1);
        hread(1'b0);                // R7 returns 5A, clears ibf
        tick();
        strobe(8'hC3);              // R5 again
        hread(1'b0);
        // R11: write and ack fall in the same cycle
        host_sel = 1'b0; host_wdata = 8'h96; host_wr = 1'b1; ack_n = 1'b0;
        tick();
        host_wr = 1'b0;
        tick();
        ack_n = 1'b1;
        tick();
        acknowledge();              // R4 byte 96 taken
        hwrite(1'b1, 8'h0C);        // R9 output enable off
        hwrite(1'b1, 8'h08);        // R9 input enable off
        hread(1'b1);
        tick(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule